// File: doc/BRIEF.md
# Embedded Flash Array Controller

This block models a byte-wide embedded flash memory together with the controller that guards it. Storage is split into a main region and a small information region, and `info_sel` picks which one a request targets. A host strobes requests over a plain parallel interface with active-low enable and strobe inputs. It can read a byte, program a byte, erase one page, or erase everything.

Flash rules apply throughout. A program can only turn ones into zeros, so the stored byte becomes the old byte ANDed with the new one. Only an erase brings bits back to one. Pages in the main region span eight rows, and pages in the information region span two rows. Program and erase take a fixed number of cycles, and `busy` is high while one runs. Changes to the array are locked out until the supply-good input has stayed high for a parameterized time. Changes are also locked out while write-protect is asserted.

Top module: `flash_ctrl`

## Requirements
- R1: A read (`ce_n`=0, `rd_n`=0, `we_n`=1) that is accepted puts the addressed byte of the selected region (`info_sel`=1 selects information) on `dout` after the rising edge that samples it. `dout` keeps its value at every other time.
- R2: A program (`ce_n`=0, `we_n`=0, `op`=2'b00) stores the old byte ANDed with `din`. A bit at zero stays zero.
- R3: A page erase (`op`=2'b01) in the main region sets every byte of the aligned 8-row page that contains `addr` to 0xFF. Other main pages and the information region are left unchanged.
- R4: A page erase in the information region sets the aligned 2-row page that contains `addr` to 0xFF and leaves the main region unchanged.
- R5: A mass erase (`op`=2'b10) sets every byte of both regions to 0xFF, whatever the values of `addr` and `info_sel`.
- R6: A modify request is refused with `err`=1 and no effect until `vcc_good` has been sampled high on CLK_MHZ*SUPPLY_US consecutive rising edges. A single low sample restarts the count.
- R7: While `wp_n`=0, every modify request is ignored and sets `prot_err`=1. Reads still return data.
- R8: An accepted modify raises `busy` for exactly PROG_CYC, PAGE_CYC or MASS_CYC cycles, chosen by its `op`. Its result can be read once `busy` falls.
- R9: Any request that arrives while `busy` is high is rejected with `err`=1. It has no effect on the array or `dout`.
- R10: A read, program or page erase whose address lies outside the selected region (information addresses at 128 or above) is rejected with `err`=1. The reserved `op`=2'b11 is rejected the same way.
- R11: Each request rewrites `err` and `prot_err`. An accepted request clears `err`, and a read clears `prot_err`.
- R12: `rst_n`=0 clears `busy`, `err`, `prot_err`, `dout` and the supply timer. The array contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Active-low modify strobe |
| rd_n | input | 1 | Active-low read strobe |
| wp_n | input | 1 | Active-low write protect |
| info_sel | input | 1 | 1 selects the information region |
| op | input | 2 | Modify kind: program, page erase, mass erase |
| addr | input | ADDR_W | Byte address within the region |
| din | input | 8 | Program data |
| vcc_good | input | 1 | Supply-good indication |
| dout | output | 8 | Read data |
| busy | output | 1 | Program or erase in progress |
| err | output | 1 | Last request was rejected |
| prot_err | output | 1 | Last modify hit write protect |

## Verification
The bench builds the block with 8-row pages of 8-byte rows, giving a 256-byte main region with four 64-byte pages. In this build the information region splits into eight 16-byte pages, so an information page erase can be shown to spare a neighbouring information page. The supply delay is one microsecond at 250 MHz, which is 250 cycles. That is short enough to probe the exact edge where modification first succeeds. Busy lengths of 3, 5 and 7 cycles give each operation its own measurable duration.

// File: rtl/flash_ctrl_pkg.sv
package flash_ctrl_pkg;

    typedef enum logic [1:0] {
        OP_PROG       = 2'b00,
        OP_PAGE_ERASE = 2'b01,
        OP_MASS_ERASE = 2'b10,
        OP_RSVD       = 2'b11
    } flash_op_e;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/flash_bank.sv
module flash_bank #(
    parameter int AW      = 7,
    parameter int PAGE_AW = 7
) (
    input  logic          clk,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          prog_en,
    input  logic          page_en,
    input  logic          all_en
);
    localparam int DEPTH = 1 << AW;

    logic [7:0]       mem [DEPTH];
    logic [DEPTH-1:0] pg_hit;
    logic [DEPTH-1:0] byte_hit;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        localparam logic [AW-1:0] IDX = AW'(g);
        assign byte_hit[g] = (wr_addr == IDX);
        if (PAGE_AW < AW) begin : g_paged
            assign pg_hit[g] = (wr_addr[AW-1:PAGE_AW] == IDX[AW-1:PAGE_AW]);
        end else begin : g_whole
            assign pg_hit[g] = 1'b1;
        end
    end

    assign rd_data = mem[rd_addr];

    // Cells carry no reset: contents survive rst_n.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (all_en || (page_en && pg_hit[i])) begin
                mem[i] <= flash_ctrl_pkg::ERASED_BYTE;
            end else if (prog_en && byte_hit[i]) begin
                mem[i] <= mem[i] & wr_data;
            end
        end
    end

endmodule

// File: rtl/supply_timer.sv
module supply_timer #(
    parameter int LIMIT = 25000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic good_in,
    output logic ready
);
    localparam int TW = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] LIM = TW'(LIMIT);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!good_in) begin
            cnt_d = '0;
        end else if (cnt_q != LIM) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign ready = (cnt_q == LIM);

endmodule

// File: rtl/flash_ctrl.sv
module flash_ctrl #(
    parameter int ADDR_W    = 16,
    parameter int MAIN_AW   = 10,
    parameter int INFO_AW   = 7,
    parameter int ROW_AW    = 6,
    parameter int CLK_MHZ   = 100,
    parameter int SUPPLY_US = 250,
    parameter int PROG_CYC  = 4,
    parameter int PAGE_CYC  = 16,
    parameter int MASS_CYC  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              rd_n,
    input  logic              wp_n,
    input  logic              info_sel,
    input  logic [1:0]        op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic              vcc_good,
    output logic [7:0]        dout,
    output logic              busy,
    output logic              err,
    output logic              prot_err
);
    import flash_ctrl_pkg::*;

    localparam int MAIN_PAGE_AW = ROW_AW + 3;
    localparam int INFO_PAGE_AW = ROW_AW + 1;
    localparam int SUPPLY_LIMIT = CLK_MHZ * SUPPLY_US;
    localparam int MAX_CYC      = max3(PROG_CYC, PAGE_CYC, MASS_CYC);
    localparam int CW           = $clog2(MAX_CYC + 1);

    typedef struct packed {
        logic              busy;
        logic [CW-1:0]     cnt;
        flash_op_e         op;
        logic              info;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
        logic [7:0]        dout;
        logic              err;
        logic              perr;
    } ctrl_t;

    ctrl_t s_d, s_q;

    logic       supply_ok;
    logic [7:0] main_rd, info_rd;
    logic       main_ok, info_ok, in_range;
    logic       is_mod, is_rd;
    logic       commit;
    flash_op_e  req_op;

    supply_timer #(.LIMIT(SUPPLY_LIMIT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .good_in (vcc_good),
        .ready   (supply_ok)
    );

    assign commit = s_q.busy && (s_q.cnt == '0);

    flash_bank #(.AW(MAIN_AW), .PAGE_AW(MAIN_PAGE_AW)) u_main (
        .clk     (clk),
        .rd_addr (addr[MAIN_AW-1:0]),
        .rd_data (main_rd),
        .wr_addr (s_q.addr[MAIN_AW-1:0]),
        .wr_data (s_q.data),
        .prog_en (commit && !s_q.info && s_q.op == OP_PROG),
        .page_en (commit && !s_q.info && s_q.op == OP_PAGE_ERASE),
        .all_en  (commit && s_q.op == OP_MASS_ERASE)
    );

    flash_bank #(.AW(INFO_AW), .PAGE_AW(INFO_PAGE_AW)) u_info (
        .clk     (clk),
        .rd_addr (addr[INFO_AW-1:0]),
        .rd_data (info_rd),
        .wr_addr (s_q.addr[INFO_AW-1:0]),
        .wr_data (s_q.data),
        .prog_en (commit && s_q.info && s_q.op == OP_PROG),
        .page_en (commit && s_q.info && s_q.op == OP_PAGE_ERASE),
        .all_en  (commit && s_q.op == OP_MASS_ERASE)
    );

    always_comb begin
        s_d      = s_q;
        req_op   = flash_op_e'(op);
        is_mod   = !ce_n && !we_n;
        is_rd    = !ce_n && we_n && !rd_n;
        main_ok  = ((addr >> MAIN_AW) == '0);
        info_ok  = ((addr >> INFO_AW) == '0);
        in_range = info_sel ? info_ok : main_ok;

        if (s_q.busy) begin
            if (s_q.cnt == '0) begin
                s_d.busy = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end

        if (is_mod) begin
            s_d.perr = !wp_n;
            if (s_q.busy || req_op == OP_RSVD || !supply_ok ||
                (req_op != OP_MASS_ERASE && !in_range)) begin
                s_d.err = 1'b1;
            end else begin
                s_d.err = 1'b0;
                if (wp_n) begin
                    s_d.busy = 1'b1;
                    s_d.op   = req_op;
                    s_d.info = info_sel;
                    s_d.addr = addr;
                    s_d.data = din;
                    case (req_op)
                        OP_PROG:       s_d.cnt = CW'(PROG_CYC - 1);
                        OP_PAGE_ERASE: s_d.cnt = CW'(PAGE_CYC - 1);
                        default:       s_d.cnt = CW'(MASS_CYC - 1);
                    endcase
                end
            end
        end else if (is_rd) begin
            s_d.perr = 1'b0;
            if (s_q.busy || !in_range) begin
                s_d.err = 1'b1;
            end else begin
                s_d.err  = 1'b0;
                s_d.dout = info_sel ? info_rd : main_rd;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.op   <= OP_PROG;
        end else begin
            s_q <= s_d;
        end
    end

    assign dout     = s_q.dout;
    assign busy     = s_q.busy;
    assign err      = s_q.err;
    assign prot_err = s_q.perr;

endmodule

// File: rtl/flash_ctrl_chk.sv
module flash_ctrl_chk #(
    parameter int ADDR_W  = 16,
    parameter int INFO_AW = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              we_n,
    input logic              rd_n,
    input logic              wp_n,
    input logic              info_sel,
    input logic [ADDR_W-1:0] addr,
    input logic              vcc_good,
    input logic              busy,
    input logic              err,
    input logic              prot_err
);
    logic any_req;
    assign any_req = !ce_n && (!we_n || !rd_n);

    // R9
    busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && any_req |=> err);

    // R7
    protect_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_n && !we_n && !wp_n |=> prot_err);

    // R7
    protect_nostart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_n && !we_n && !wp_n && !busy |=> !busy);

    // R10
    info_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_n && we_n && !rd_n && info_sel && ((addr >> INFO_AW) != '0) |=> err);

    // R6
    supply_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(vcc_good, 2));

    // R12
    reset_clear_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> !busy && !err && !prot_err);

endmodule

bind flash_ctrl flash_ctrl_chk #(.ADDR_W(ADDR_W), .INFO_AW(INFO_AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .we_n     (we_n),
    .rd_n     (rd_n),
    .wp_n     (wp_n),
    .info_sel (info_sel),
    .addr     (addr),
    .vcc_good (vcc_good),
    .busy     (busy),
    .err      (err),
    .prot_err (prot_err)
);

// File: tb/flash_ctrl_test.sv
module flash_ctrl_test;

    localparam int LIMIT = 250;
    localparam int PCYC  = 3;
    localparam int ECYC  = 5;
    localparam int MCYC  = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, rd_n = 1'b1, wp_n = 1'b1;
    logic        info_sel = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [15:0] addr = '0;
    logic [7:0]  din = '0;
    logic        vcc_good = 1'b0;
    logic [7:0]  dout;
    logic        busy, err, prot_err;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    flash_ctrl #(
        .ADDR_W(16), .MAIN_AW(8), .INFO_AW(7), .ROW_AW(3),
        .CLK_MHZ(250), .SUPPLY_US(1),
        .PROG_CYC(PCYC), .PAGE_CYC(ECYC), .MASS_CYC(MCYC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .rd_n(rd_n),
        .wp_n(wp_n), .info_sel(info_sel), .op(op), .addr(addr), .din(din),
        .vcc_good(vcc_good), .dout(dout), .busy(busy), .err(err),
        .prot_err(prot_err)
    );

    // kind: 0 program, 1 page erase, 2 mass erase, 3 read with expected data
    localparam logic [18:0] VEC [24] = '{
        {2'd0, 1'b0, 8'h10, 8'hF0}, {2'd3, 1'b0, 8'h10, 8'hF0},
        {2'd0, 1'b0, 8'h10, 8'h3C}, {2'd3, 1'b0, 8'h10, 8'h30},
        {2'd0, 1'b0, 8'h50, 8'h0F}, {2'd3, 1'b0, 8'h50, 8'h0F},
        {2'd0, 1'b1, 8'h05, 8'hA5}, {2'd3, 1'b1, 8'h05, 8'hA5},
        {2'd0, 1'b1, 8'h25, 8'h5A}, {2'd3, 1'b1, 8'h25, 8'h5A},
        {2'd1, 1'b0, 8'h3F, 8'h00}, {2'd3, 1'b0, 8'h10, 8'hFF},
        {2'd3, 1'b0, 8'h50, 8'h0F}, {2'd3, 1'b1, 8'h05, 8'hA5},
        {2'd1, 1'b1, 8'h0A, 8'h00}, {2'd3, 1'b1, 8'h05, 8'hFF},
        {2'd3, 1'b1, 8'h25, 8'h5A}, {2'd3, 1'b0, 8'h50, 8'h0F},
        {2'd0, 1'b0, 8'hFF, 8'h00}, {2'd3, 1'b0, 8'hFF, 8'h00},
        {2'd2, 1'b0, 8'h77, 8'h00}, {2'd3, 1'b0, 8'h50, 8'hFF},
        {2'd3, 1'b1, 8'h25, 8'hFF}, {2'd3, 1'b0, 8'hFF, 8'hFF}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a negedge; the request is sampled at the next rising edge,
    // and the task returns at the negedge after it.
    task automatic do_req(input logic w, input logic r, input logic wp,
                          input logic inf, input logic [1:0] o,
                          input logic [15:0] a, input logic [7:0] d);
        ce_n = 1'b0; we_n = !w; rd_n = !r; wp_n = wp;
        info_sel = inf; op = o; addr = a; din = d;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; rd_n = 1'b1; wp_n = 1'b1;
    endtask

    task automatic rd(input logic inf, input logic [15:0] a);
        do_req(1'b0, 1'b1, 1'b1, inf, 2'b00, a, 8'h00);
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 busy", 16'(busy), 16'd0);
        chk("R12 err", 16'(err), 16'd0);
        chk("R12 prot_err", 16'(prot_err), 16'd0);
        chk("R12 dout", 16'(dout), 16'h00);

        rst_n = 1'b1;
        vcc_good = 1'b1;
        repeat (LIMIT - 1) @(negedge clk);
        // R6: sampled at edge LIMIT, one short of the window
        do_req(1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 16'h0000, 8'h00);
        chk("R6 early err", 16'(err), 16'd1);
        chk("R6 early busy", 16'(busy), 16'd0);
        do_req(1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 16'h0000, 8'h00);
        chk("R6 ready busy", 16'(busy), 16'd1);
        chk("R11 accepted clears err", 16'(err), 16'd0);
        busy_len(n);

        // R6: one low sample restarts the window
        vcc_good = 1'b0;
        @(negedge clk);
        vcc_good = 1'b1;
        do_req(1'b1, 1'b0, 1'b1, 1'b0, 2'b10, 16'h0000, 8'h00);
        chk("R6 restart err", 16'(err), 16'd1);
        chk("R6 restart busy", 16'(busy), 16'd0);
        repeat (LIMIT + 2) @(negedge clk);

        // R5: start from a known erased array
        do_req(1'b1, 1'b0, 1'b1, 1'b0, 2'b10, 16'h0000, 8'h00);
        busy_len(n);
        chk("R8 mass len", 16'(n), 16'(MCYC));

        // Table walk: R1 R2 R3 R4 R5 R8
        for (int i = 0; i < 24; i++) begin
            logic [1:0] k;
            k = VEC[i][18:17];
            if (k == 2'd3) begin
                rd(VEC[i][16], {8'h00, VEC[i][15:8]});
                chk($sformatf("R1/R2/R3/R4/R5 read vec %0d", i), 16'(dout),
                    16'(VEC[i][7:0]));
            end else begin
                do_req(1'b1, 1'b0, 1'b1, VEC[i][16], k, {8'h00, VEC[i][15:8]},
                       VEC[i][7:0]);
                busy_len(n);
                chk($sformatf("R8 busy length vec %0d", i), 16'(n),
                    (k == 2'd0) ? 16'(PCYC) : (k == 2'd1) ? 16'(ECYC) : 16'(MCYC));
            end
        end

        // R7: write protect blocks program, reads still work
        do_req(1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 16'h0020, 8'h00);
        chk("R7 prot_err", 16'(prot_err), 16'd1);
        chk("R7 no busy", 16'(busy), 16'd0);
        do_req(1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 16'h0020, 8'h00);
        chk("R7 read under protect", 16'(dout), 16'h00FF);
        chk("R11 read clears prot_err", 16'(prot_err), 16'd0);
        do_req(1'b1, 1'b0, 1'b0, 1'b0, 2'b10, 16'h0000, 8'h00);
        chk("R7 mass erase blocked", 16'(busy), 16'd0);

        // R9: requests while busy
        rd(1'b0, 16'h0050);
        do_req(1'b1, 1'b0, 1'b1, 1'b0, 2'b01, 16'h0040, 8'h00);
        do_req(1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 16'h0021, 8'h00);
        chk("R9 program while busy err", 16'(err), 16'd1);
        rd(1'b0, 16'h00FF);
        chk("R9 read while busy err", 16'(err), 16'd1);
        chk("R9 read while busy dout held", 16'(dout), 16'h00FF);
        busy_len(n);
        rd(1'b0, 16'h0021);
        chk("R9 rejected program no effect", 16'(dout), 16'h00FF);
        chk("R11 read clears err", 16'(err), 16'd0);

        // R10: out-of-range and reserved op
        rd(1'b1, 16'h0080);
        chk("R10 info read 0x80 err", 16'(err), 16'd1);
        chk("R10 info read dout held", 16'(dout), 16'h00FF);
        do_req(1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 16'h0100, 8'h00);
        chk("R10 main program 0x100 err", 16'(err), 16'd1);
        chk("R10 main program no busy", 16'(busy), 16'd0);
        do_req(1'b1, 1'b0, 1'b1, 1'b0, 2'b11, 16'h0000, 8'h00);
        chk("R10 reserved op err", 16'(err), 16'd1);
        chk("R10 reserved op no busy", 16'(busy), 16'd0);
        rd(1'b1, 16'h007F);
        chk("R10 info 0x7F ok", 16'(err), 16'd0);

        // R12: reset keeps the array, clears flags and timer
        do_req(1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 16'h0030, 8'h12);
        busy_len(n);
        do_req(1'b1, 1'b0, 1'b1, 1'b0, 2'b10, 16'h0000, 8'h00);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R12 busy cleared mid-op", 16'(busy), 16'd0);
        rst_n = 1'b1;
        rd(1'b0, 16'h0030);
        chk("R12 array kept", 16'(dout), 16'h0012);
        do_req(1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 16'h0030, 8'h00);
        chk("R12 timer cleared", 16'(err), 16'd1);
        rd(1'b0, 16'h0030);
        chk("R12 refused write no effect", 16'(dout), 16'h0012);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule